// File: doc/BRIEF.md
# T1 Framer Event Interrupt Controller

This block sits behind the receive framer of one T1/J1 channel. It turns raw framer indications into qualified events. It takes per-frame strobes for framing-bit errors, CRC-6 mismatches and superframe boundaries, the levels for in-frame status and mimic-pattern presence, and a realignment strobe that carries the new alignment position. From these it derives six events. Some of them are composite: a count of framing errors in each superframe, a bit-error source that depends on the frame format, transitions in both directions of two status levels, and a comparison against the alignment position held before.

Each event sets a sticky status flag whether or not its enable is set. A small register port gives the host access to a 6-bit enable register and to the status register. A status flag is cleared by writing 1 to it. The active-low interrupt output is asserted while any flag is set together with its enable. The asynchronous reset is released synchronously inside the block.

Top module: `t1_evt_irq_ctrl`

## Requirements
- R1: The enable register sits at address 0. Bits 5..0 are writable and read back as written. Bits 7..6 always read 0. Every enable bit is 0 after reset.
- R2: A framing-bit-error strobe sets status bit 4 on the following clock edge.
- R3: Status bit 3 is the bit-error event. When `esf_mode_i` is 0 it is set by a framing-bit-error strobe. When `esf_mode_i` is 1 it is set only by a CRC-6 mismatch strobe.
- R4: Status bit 2 is set on the second framing-bit error since the last superframe-boundary strobe, and at most once per superframe. An error in the same cycle as a boundary strobe counts as the first error of the new superframe.
- R5: Status bit 1 is set on every change of `mimic_i`, in either direction. The level before reset is taken as absent (0).
- R6: Status bit 0 is set on every change of `in_frame_i`, in either direction. The level before reset is taken as out-of-frame (0).
- R7: Status bit 5 is set on a realignment strobe whose position differs from the position stored at the previous realignment. The first realignment after reset always sets it.
- R8: The status register sits at address 1 and reads as {2'b00, flags}. Flags stay set until the host writes 1 to them. An event in the same cycle as its clear leaves the flag set.
- R9: `irq_n_o` is 0 exactly while some status bit and the matching enable bit are both 1. An event whose enable is 0 still sets its status bit.
- R10: While reset is asserted and for two clocks after its release, all flags and enables are 0 and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbit_err_i | input | 1 | Framing-bit error strobe |
| crc_err_i | input | 1 | CRC-6 mismatch strobe |
| sf_bound_i | input | 1 | Superframe boundary strobe |
| esf_mode_i | input | 1 | 1 = extended superframe format, 0 = superframe format |
| in_frame_i | input | 1 | In-frame status level |
| mimic_i | input | 1 | Mimic pattern present level |
| realign_i | input | 1 | Realignment done strobe |
| realign_pos_i | input | POS_W | Alignment position carried with the realignment strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 enable, 1 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
Most of the state is exposed directly at the status port. A wrong flag bit is therefore visible on a status read in the cycle right after the strobe that should or should not have set it. The hidden state is the per-superframe error counter, the two stored levels and the stored alignment position. A fault there shows only when the next strobe or level change arrives: a missing or duplicated severe flag, a spurious or missing transition flag, or an alignment flag on an unchanged position. The bench therefore repeats boundary, error and realignment patterns often enough that each hidden register is used again within a few cycles of being written. It also sweeps every enable value against a fully set status register, so that any masking fault shows at once on `irq_n_o`.

// File: rtl/t1_evt_pkg.sv
package t1_evt_pkg;
  localparam int EVT_N  = 6;
  localparam int SYN_B  = 0;
  localparam int MIM_B  = 1;
  localparam int SEV_B  = 2;
  localparam int BE_B   = 3;
  localparam int FE_B   = 4;
  localparam int ALN_B  = 5;
  localparam logic ADDR_EN = 1'b0;
  localparam logic ADDR_ST = 1'b1;
  typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/t1_rst_sync.sv
module t1_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/t1_evt_detect.sv
module t1_evt_detect
  import t1_evt_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int SEV_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fbit_err,
  input  logic             crc_err,
  input  logic             sf_bound,
  input  logic             esf_mode,
  input  logic             in_frame,
  input  logic             mimic,
  input  logic             realign,
  input  logic [POS_W-1:0] realign_pos,
  output evt_vec_t         evt
);
  localparam int CNT_W = $clog2(SEV_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SEV_LIMIT);
  localparam logic [CNT_W-1:0] CNT_TRIG = CNT_W'(SEV_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mim_q, inf_q, have_q;
  logic [POS_W-1:0] pos_q;
  logic             sev_evt, aln_evt;

  // next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    sev_evt = 1'b0;
    if (sf_bound) begin
      cnt_d = fbit_err ? CNT_W'(1) : '0;
    end else if (fbit_err) begin
      if (cnt_q == CNT_TRIG) sev_evt = 1'b1;
      if (cnt_q != CNT_MAX)  cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign aln_evt = realign && (!have_q || (realign_pos != pos_q));

  always_comb begin
    evt        = '0;
    evt[FE_B]  = fbit_err;
    evt[BE_B]  = esf_mode ? crc_err : fbit_err;
    evt[SEV_B] = sev_evt;
    evt[MIM_B] = mimic ^ mim_q;
    evt[SYN_B] = in_frame ^ inf_q;
    evt[ALN_B] = aln_evt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mim_q <= 1'b0;
      inf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mim_q <= mimic;
      inf_q <= in_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      pos_q  <= '0;
    end else if (realign) begin
      have_q <= 1'b1;
      pos_q  <= realign_pos;
    end
  end
endmodule

// File: rtl/t1_evt_regs.sv
module t1_evt_regs
  import t1_evt_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evt_vec_t         evt,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output evt_vec_t         stat_q,
  output evt_vec_t         en_q,
  output logic             irq_n
);
  evt_vec_t stat_d, clr;
  logic     en_ld;
  logic     unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:EVT_N];
  assign clr   = (wr_en && addr == ADDR_ST) ? wr_data[EVT_N-1:0] : '0;
  assign en_ld = wr_en && (addr == ADDR_EN);

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    assign stat_d[i] = evt[i] | (stat_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= wr_data[EVT_N-1:0];
  end

  always_comb begin
    rd_data = '0;
    rd_data[EVT_N-1:0] = (addr == ADDR_ST) ? stat_q : en_q;
  end

  assign irq_n = ~|(stat_q & en_q);
endmodule

// File: rtl/t1_evt_irq_ctrl.sv
module t1_evt_irq_ctrl
  import t1_evt_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int SEV_LIMIT = 2,
  parameter int REG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fbit_err_i,
  input  logic             crc_err_i,
  input  logic             sf_bound_i,
  input  logic             esf_mode_i,
  input  logic             in_frame_i,
  input  logic             mimic_i,
  input  logic             realign_i,
  input  logic [POS_W-1:0] realign_pos_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_n_o
);
  logic     rst_sync_n;
  evt_vec_t evt;
  evt_vec_t stat_q;
  evt_vec_t en_q;

  t1_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  t1_evt_detect #(.POS_W(POS_W), .SEV_LIMIT(SEV_LIMIT)) det_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fbit_err    (fbit_err_i),
    .crc_err     (crc_err_i),
    .sf_bound    (sf_bound_i),
    .esf_mode    (esf_mode_i),
    .in_frame    (in_frame_i),
    .mimic       (mimic_i),
    .realign     (realign_i),
    .realign_pos (realign_pos_i),
    .evt         (evt)
  );

  t1_evt_regs #(.REG_W(REG_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt     (evt),
    .wr_en   (reg_wr_i),
    .addr    (reg_addr_i),
    .wr_data (reg_wdata_i),
    .rd_data (reg_rdata_o),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .irq_n   (irq_n_o)
  );
endmodule

// File: rtl/t1_evt_irq_chk.sv
module t1_evt_irq_chk
  import t1_evt_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             fbit_err_i,
  input logic             crc_err_i,
  input logic             esf_mode_i,
  input logic             realign_i,
  input logic             reg_wr_i,
  input logic             reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input evt_vec_t         stat_q,
  input logic             irq_n_o
);
  for (genvar i = 0; i < EVT_N; i++) begin : g_hold
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (stat_q[i] && !(reg_wr_i && reg_addr_i == ADDR_ST && reg_wdata_i[i])) |=> stat_q[i])
      else $error("sticky_hold_chk bit %0d", i);
  end

  // R2
  fbit_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fbit_err_i |=> stat_q[FE_B])
    else $error("fbit_set_chk");

  // R3
  crc_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (esf_mode_i && crc_err_i) |=> stat_q[BE_B])
    else $error("crc_set_chk");

  // R4
  sev_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(stat_q[SEV_B]) |-> $past(fbit_err_i))
    else $error("sev_cause_chk");

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && reg_addr_i == ADDR_EN && reg_wdata_i[EVT_N-1:0] == '0) |=> irq_n_o)
    else $error("mask_all_chk");

  // R7
  aln_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && reg_addr_i == ADDR_ST && reg_wdata_i[ALN_B] && !realign_i) |=> !stat_q[ALN_B])
    else $error("aln_clear_chk");
endmodule

bind t1_evt_irq_ctrl t1_evt_irq_chk #(.REG_W(REG_W)) chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .fbit_err_i  (fbit_err_i),
  .crc_err_i   (crc_err_i),
  .esf_mode_i  (esf_mode_i),
  .realign_i   (realign_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .stat_q      (stat_q),
  .irq_n_o     (irq_n_o)
);

// File: tb/t1_evt_irq_ctrl_tb_top.sv
module t1_evt_irq_ctrl_tb_top;
  localparam int POS_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic fe, crc, bnd, esf, inf, mim, rl, wr, addr;
  logic [POS_W-1:0] pos;
  logic [7:0] wd;
  logic [7:0] rd;
  logic irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [5:0] m_stat, m_en;
  int         m_cnt;
  logic       m_mim, m_inf, m_have;
  logic [POS_W-1:0] m_pos;

  always #2 clk = ~clk;

  t1_evt_irq_ctrl #(.POS_W(POS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fbit_err_i(fe), .crc_err_i(crc), .sf_bound_i(bnd),
    .esf_mode_i(esf), .in_frame_i(inf), .mimic_i(mim), .realign_i(rl),
    .realign_pos_i(pos), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .irq_n_o(irq_n)
  );

  function automatic string bit_req(input int b);
    case (b)
      5: return "R7";
      4: return "R2";
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_stat = '0; m_en = '0; m_cnt = 0;
    m_mim = 1'b0; m_inf = 1'b0; m_have = 1'b0; m_pos = '0;
  endtask

  task automatic model_step();
    logic [5:0] ev, clr;
    ev = '0;
    ev[4] = fe;
    ev[3] = esf ? crc : fe;
    if (bnd) m_cnt = fe ? 1 : 0;
    else if (fe) begin
      if (m_cnt == 1) ev[2] = 1'b1;
      if (m_cnt < 2) m_cnt++;
    end
    ev[1] = mim != m_mim; m_mim = mim;
    ev[0] = inf != m_inf; m_inf = inf;
    ev[5] = rl && (!m_have || pos != m_pos);
    if (rl) begin m_have = 1'b1; m_pos = pos; end
    clr = (wr && addr) ? wd[5:0] : 6'h0;
    m_stat = (m_stat & ~clr) | ev;
    if (wr && !addr) m_en = wd[5:0];
  endtask

  task automatic compare();
    logic [7:0] exp;
    exp = addr ? {2'b00, m_stat} : {2'b00, m_en};
    if (!addr) check("R1", rd, exp);
    else begin
      n_chk++;
      if (rd !== exp) begin
        n_fail++;
        for (int b = 0; b < 8; b++)
          if (rd[b] !== exp[b])
            $display("FAIL %s/R8 bit%0d actual=%h expected=%h at %0t",
                     b < 6 ? bit_req(b) : "R8", b, rd, exp, $time);
      end
    end
    check("R9", {7'h0, irq_n}, {7'h0, ~|(m_stat & m_en)});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
    @(negedge clk);
    fe = 0; crc = 0; bnd = 0; rl = 0; wr = 0;
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    addr = a; wr = 1'b1; wd = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fe = 0; crc = 0; bnd = 0; esf = 0; inf = 0; mim = 0; rl = 0; wr = 0; addr = 0;
    pos = '0; wd = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    check("R10", {7'h0, irq_n}, 8'h01);
    check("R10", rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    addr = 1'b1; #0;
    check("R10", rd, 8'h00);
    repeat (2) tick();

    // R1: enable register readback, reserved bits read 0
    wreg(1'b0, 8'hFF); addr = 1'b0; tick();
    wreg(1'b0, 8'h00);
    addr = 1'b1;

    // R2 R3 R4: superframe format, two errors then a third in same superframe
    esf = 0;
    bnd = 1; tick();
    fe = 1; tick();
    tick();
    fe = 1; tick();
    fe = 1; tick();
    wreg(1'b1, 8'h3F);
    // R4: error coincident with boundary counts as first
    fe = 1; bnd = 1; tick();
    fe = 1; tick();
    // R3: ESF, crc alone sets bit error, framing error alone does not
    wreg(1'b1, 8'h3F);
    esf = 1;
    crc = 1; tick();
    wreg(1'b1, 8'h3F);
    fe = 1; tick();
    crc = 1; esf = 0; tick();
    // R5 R6: transitions in both directions
    mim = 1; tick(); tick();
    mim = 0; tick();
    inf = 1; tick(); tick();
    inf = 0; tick();
    // R7: first realign, same position, new position
    wreg(1'b1, 8'h3F);
    rl = 1; pos = 8'd0; tick();
    wreg(1'b1, 8'h20);
    rl = 1; pos = 8'd0; tick();
    rl = 1; pos = 8'd9; tick();
    // R8: clear in same cycle as event keeps flag
    addr = 1'b1; wr = 1'b1; wd = 8'h10; fe = 1; tick();
    wreg(1'b1, 8'h10);

    // R9: all flags set, sweep every enable value
    esf = 0; bnd = 1; tick();
    fe = 1; tick(); fe = 1; tick();
    mim = 1; inf = 1; rl = 1; pos = 8'd3; tick();
    for (int e = 0; e < 64; e++) begin
      wreg(1'b0, e[7:0]);
    end
    for (int e = 0; e < 64; e++) begin
      wreg(1'b0, 8'h3F);
      wreg(1'b1, e[7:0]);
    end

    // near-exhaustive mixed stimulus on a small position space
    for (int k = 0; k < 4000; k++) begin
      fe   = ($urandom % 3) == 0;
      crc  = ($urandom % 3) == 0;
      bnd  = ($urandom % 6) == 0;
      esf  = ($urandom % 8) == 0 ? ~esf : esf;
      inf  = ($urandom % 5) == 0 ? ~inf : inf;
      mim  = ($urandom % 5) == 0 ? ~mim : mim;
      rl   = ($urandom % 4) == 0;
      pos  = POS_W'($urandom % 3);
      addr = $urandom % 2;
      wr   = ($urandom % 4) == 0;
      wd   = 8'($urandom);
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule